// File: doc/BRIEF.md
# Cipher Round Key Expansion Step

This block produces the next round key of a word-based block-cipher key schedule from the previous round key and the round number. It has no clock and no state. A controller that stores the key feeds each output back as the next input and raises the round number by one each time. The block then walks the whole schedule, one round key per step.

Every new 32-bit word is the XOR of the word one key-length earlier and a transformed copy of the word just before it. The first word of each step takes the most complex path. That word is built from the last word of the previous key, which is rotated by one byte, byte-substituted, and mixed with a round constant. The remaining words chain on the freshly produced words. With the 256-bit key setting, the fifth word also gets a substitution-only path.

The parameter `NK` gives the key length in 32-bit words: 4 for a 128-bit key (the default) and 8 for a 256-bit key. The byte substitution is computed from finite-field arithmetic. The round constants are derived by repeated doubling. No tables are stored.

Top module: `kx_round_step`

## Requirements
- R1: `next_key` is a pure combinational function of `prev_key` and `round_idx`. It settles in the same cycle the inputs change, and the same inputs always give the same output.
- R2: Word j of a key occupies bits `[32*NK-1-32*j -: 32]`, so word 0 is the most significant. Within a word, byte 0 sits in bits 31:24.
- R3: Output word 0 equals input word 0 XOR (SubWord(RotWord(input word NK-1)) XOR round constant).
- R4: RotWord turns bytes [a0,a1,a2,a3] into [a1,a2,a3,a0]. For example, 00000053 becomes 00005300.
- R5: The byte substitution is the standard forward substitution box: the multiplicative inverse in GF(2^8) modulo x^8+x^4+x^3+x+1, followed by the affine map with constant 63. For example, sub(00)=63 and sub(53)=ed.
- R6: `round_idx` must lie in 1..MAX_RND, which is 10 for NK=4 and 7 for NK=8. The round constant is 01,02,04,08,10,20,40,80,1b,36 (hex) for rounds 1..10. It sits in bits 31:24 and the other bytes are zero.
- R7: Every output word j ≥ 1 that R8 does not cover equals input word j XOR output word j-1.
- R8: When NK > 6, output word 4 equals input word 4 XOR SubWord(output word 3), with no rotation and no round constant.
- R9: For NK=4, chaining ten steps from key 2b7e151628aed2a6abf7158809cf4f3c gives a0fafe1788542cb123a339392a6c7605 after round 1 and d014f9a8c9ee2589e13f0cc8b6630ca6 after round 10.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| prev_key | input | 32*NK | Previous round key, word 0 in the top bits |
| round_idx | input | RND_W | Index of the round key being produced (1..MAX_RND) |
| next_key | output | 32*NK | Next round key, same word layout as `prev_key` |

## Verification
The checker assumes that `round_idx` is always a legal step number, from 1 to the last round that a key of NK words needs. Outside that range no round constant is defined, so the relations below are not required to hold there. The bench sets the round input to 1 before time zero. Every random draw is one plus a value modulo the legal count, so the stimulus never leaves the range. Key bits are unconstrained, and any 32*NK-bit value is a valid previous key.

// File: rtl/kx_pkg.sv
package kx_pkg;

    typedef logic [7:0]  byte_t;
    typedef logic [31:0] word_t;

    // How a word is transformed before the XOR with the older word
    typedef enum logic [1:0] {
        XF_CHAIN   = 2'd0,
        XF_ROT_SUB = 2'd1,
        XF_SUB     = 2'd2
    } xform_e;

    function automatic byte_t gf_dbl(input byte_t a);
        return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
    endfunction

    function automatic byte_t gf_mul(input byte_t a, input byte_t b);
        byte_t acc = 8'h00;
        byte_t sh  = a;
        for (int k = 0; k < 8; k++) begin
            if (b[k]) acc = acc ^ sh;
            sh = gf_dbl(sh);
        end
        return acc;
    endfunction

    // a^254 = a^-1 for a != 0, and 0 for a = 0
    function automatic byte_t gf_inv(input byte_t a);
        byte_t sq  = a;
        byte_t acc = 8'h01;
        for (int k = 1; k < 8; k++) begin
            sq  = gf_mul(sq, sq);
            acc = gf_mul(acc, sq);
        end
        return acc;
    endfunction

    function automatic byte_t affine_fwd(input byte_t b);
        return b ^ {b[6:0], b[7]} ^ {b[5:0], b[7:6]}
                 ^ {b[4:0], b[7:5]} ^ {b[3:0], b[7:4]} ^ 8'h63;
    endfunction

    function automatic byte_t sbox_fwd(input byte_t b);
        return affine_fwd(gf_inv(b));
    endfunction

    function automatic word_t rot_word(input word_t w);
        return {w[23:0], w[31:24]};
    endfunction

    // Round constant byte for round r: doubled r-1 times from 01
    function automatic byte_t rcon_byte(input int unsigned r);
        byte_t c = 8'h01;
        for (int unsigned k = 2; k < 16; k++) begin
            if (k <= r) c = gf_dbl(c);
        end
        return c;
    endfunction

endpackage

// File: rtl/kx_sbox.sv
module kx_sbox
    import kx_pkg::*;
(
    input  byte_t din,
    output byte_t dout
);
    assign dout = sbox_fwd(din);
endmodule

// File: rtl/kx_word_xform.sv
module kx_word_xform
    import kx_pkg::*;
#(
    parameter xform_e MODE = XF_ROT_SUB
)(
    input  word_t src,
    input  byte_t rc,
    output word_t dst
);
    word_t pre;
    word_t subbed;

    generate
        if (MODE == XF_ROT_SUB) begin : g_rot
            assign pre = rot_word(src);
        end else begin : g_norot
            assign pre = src;
        end

        for (genvar b = 0; b < 4; b++) begin : g_byte
            kx_sbox u_sbox (
                .din  (pre[8*b +: 8]),
                .dout (subbed[8*b +: 8])
            );
        end
    endgenerate

    assign dst = subbed ^ {rc, 24'h000000};
endmodule

// File: rtl/kx_round_step.sv
module kx_round_step
    import kx_pkg::*;
#(
    parameter int NK    = 4,
    parameter int RND_W = 4
)(
    input  logic [32*NK-1:0] prev_key,
    input  logic [RND_W-1:0] round_idx,
    output logic [32*NK-1:0] next_key
);
    localparam int KEY_W = 32 * NK;

    word_t prev_w [NK];
    byte_t rc;

    assign rc = rcon_byte(32'(round_idx));

    generate
        for (genvar j = 0; j < NK; j++) begin : g_w
            word_t tmp;
            word_t nw;

            assign prev_w[j] = prev_key[KEY_W-1-32*j -: 32];

            if (j == 0) begin : g_head
                kx_word_xform #(.MODE(XF_ROT_SUB)) u_xf (
                    .src (prev_w[NK-1]),
                    .rc  (rc),
                    .dst (tmp)
                );
            end else if (NK > 6 && j == 4) begin : g_mid
                kx_word_xform #(.MODE(XF_SUB)) u_xf (
                    .src (g_w[j-1].nw),
                    .rc  (8'h00),
                    .dst (tmp)
                );
            end else begin : g_chain
                assign tmp = g_w[j-1].nw;
            end

            assign nw = prev_w[j] ^ tmp;
            assign next_key[KEY_W-1-32*j -: 32] = nw;
        end
    endgenerate
endmodule

// File: rtl/kx_round_step_chk.sv
module kx_round_step_chk
    import kx_pkg::*;
#(
    parameter int NK    = 4,
    parameter int RND_W = 4
)(
    input logic [32*NK-1:0] prev_key,
    input logic [RND_W-1:0] round_idx,
    input logic [32*NK-1:0] next_key
);
    localparam int MAX_RND = (4 * (NK + 6) + 3) / NK;

    function automatic word_t wsel(input logic [32*NK-1:0] k, input int j);
        return k[32*NK-1-32*j -: 32];
    endfunction

    word_t d0;
    word_t plast;
    byte_t rc_seen;
    byte_t rc_want;

    assign d0      = wsel(next_key, 0) ^ wsel(prev_key, 0);
    assign plast   = wsel(prev_key, NK-1);
    assign rc_seen = d0[31:24] ^ sbox_fwd(plast[23:16]);

    always_comb begin
        if (round_idx <= RND_W'(8) && round_idx != '0)
            rc_want = 8'(8'd1 << (round_idx - 1'b1));
        else if (round_idx == RND_W'(9))
            rc_want = 8'h1b;
        else
            rc_want = 8'h36;
    end

    always_comb begin
        AST_ROUND_LEGAL: assert (round_idx >= 1 && 32'(round_idx) <= MAX_RND)
            else $error("round index out of range"); // R6
        AST_HEAD_LOW_BYTES: assert (d0[23:0] == {sbox_fwd(plast[15:8]),
                                                 sbox_fwd(plast[7:0]),
                                                 sbox_fwd(plast[31:24])})
            else $error("head word rotate/substitute mismatch"); // R4
        AST_RCON_MSB: assert (rc_seen == rc_want)
            else $error("round constant mismatch"); // R6
        for (int j = 1; j < NK; j++) begin
            if (!(NK > 6 && j == 4)) begin
                AST_CHAIN_XOR: assert ((wsel(next_key, j) ^ wsel(next_key, j-1))
                                       == wsel(prev_key, j))
                    else $error("chained word mismatch"); // R7
            end
        end
        if (NK > 6) begin
            AST_SUB_ONLY: assert ((wsel(next_key, 4) ^ wsel(prev_key, 4)) ==
                                  {sbox_fwd(wsel(next_key, 3) >> 24),
                                   sbox_fwd(wsel(next_key, 3) >> 16),
                                   sbox_fwd(wsel(next_key, 3) >> 8),
                                   sbox_fwd(wsel(next_key, 3))})
                else $error("substitute-only word mismatch"); // R8
        end
    end
endmodule

bind kx_round_step kx_round_step_chk #(.NK(NK), .RND_W(RND_W)) u_chk (.*);

// File: tb/kx_round_step_bench.sv
module kx_round_step_bench;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;   // 50 MHz

    logic [127:0] key4 = '0;
    logic [3:0]   rnd4 = 4'd1;
    logic [127:0] out4;
    logic [255:0] key8 = '0;
    logic [3:0]   rnd8 = 4'd1;
    logic [255:0] out8;

    kx_round_step #(.NK(4), .RND_W(4)) u_kx_round_step (
        .prev_key (key4), .round_idx (rnd4), .next_key (out4));

    kx_round_step #(.NK(8), .RND_W(4)) u_kx_round_step_w8 (
        .prev_key (key8), .round_idx (rnd8), .next_key (out8));

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;
    logic [7:0] sb [256];

    // ---------- reference model ----------
    function automatic logic [7:0] ref_mul(input logic [7:0] a, input logic [7:0] b);
        logic [15:0] p = '0;
        for (int k = 0; k < 8; k++) if (b[k]) p = p ^ (16'(a) << k);
        for (int k = 15; k >= 8; k--) if (p[k]) p = p ^ (16'h011b << (k - 8));
        return p[7:0];
    endfunction

    function automatic logic [7:0] ref_sbox(input logic [7:0] x);
        logic [7:0] inv = 8'h00;
        logic [7:0] y;
        for (int c = 1; c < 256; c++)
            if (x != 0 && ref_mul(x, 8'(c)) == 8'h01) inv = 8'(c);
        for (int i = 0; i < 8; i++)
            y[i] = inv[i] ^ inv[(i+4)%8] ^ inv[(i+5)%8] ^ inv[(i+6)%8]
                 ^ inv[(i+7)%8] ^ (8'h63 >> i);
        return y;
    endfunction

    function automatic logic [7:0] ref_rc(input int r);
        case (r)
            1: return 8'h01;  2: return 8'h02;  3: return 8'h04;  4: return 8'h08;
            5: return 8'h10;  6: return 8'h20;  7: return 8'h40;  8: return 8'h80;
            9: return 8'h1b;  default: return 8'h36;
        endcase
    endfunction

    function automatic logic [31:0] ref_subw(input logic [31:0] w);
        return {sb[w[31:24]], sb[w[23:16]], sb[w[15:8]], sb[w[7:0]]};
    endfunction

    function automatic logic [255:0] ref_next(input logic [255:0] k, input int nk, input int r);
        logic [31:0] w [16];
        logic [31:0] t;
        logic [255:0] res = '0;
        for (int j = 0; j < nk; j++) w[j] = k[32*nk-1-32*j -: 32];
        for (int j = 0; j < nk; j++) begin
            t = w[j+nk-1];
            if (j == 0)
                t = ref_subw({t[23:0], t[31:24]}) ^ {ref_rc(r), 24'h0};
            else if (nk > 6 && j == 4)
                t = ref_subw(t);
            w[j+nk] = w[j] ^ t;
        end
        for (int j = 0; j < nk; j++) res[32*nk-1-32*j -: 32] = w[j+nk];
        return res;
    endfunction

    // ---------- helpers ----------
    task automatic check(input string req, input logic [255:0] got, input logic [255:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic apply4(input logic [127:0] k, input int r);
        @(posedge clk);
        key4 = k;
        rnd4 = 4'(r);
        @(negedge clk);
    endtask

    task automatic apply8(input logic [255:0] k, input int r);
        @(posedge clk);
        key8 = k;
        rnd8 = 4'(r);
        @(negedge clk);
    endtask

    function automatic logic [255:0] rand_key();
        logic [255:0] v;
        for (int i = 0; i < 8; i++) v[32*i +: 32] = $urandom;
        return v;
    endfunction

    // ---------- watchdog ----------
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    // ---------- stimulus ----------
    initial begin
        logic [127:0] k;
        logic [255:0] rk;
        int r;
        void'($urandom(32'd1234));
        for (int i = 0; i < 256; i++) sb[i] = ref_sbox(8'(i));
        repeat (3) @(posedge clk);
        rst = 1'b0;

        // R5, R6: zero key at round 1 (reset-time input state)
        @(negedge clk);
        check("R5 zero key round1", {128'h0, out4}, {128'h0, {4{32'h62636363}}});

        // R4, R5: single byte in the last word
        apply4(128'h00000053, 1);
        check("R4 rotate order", {128'h0, out4},
              {128'h0, 128'h6263ed63_6263ed63_6263ed63_6263ed30});

        // R2, R9: known key, round 1
        apply4(128'h2b7e1516_28aed2a6_abf71588_09cf4f3c, 1);
        check("R9 round1 key", {128'h0, out4},
              {128'h0, 128'ha0fafe17_88542cb1_23a33939_2a6c7605});

        // R9: full ten-step chain
        k = 128'h2b7e1516_28aed2a6_abf71588_09cf4f3c;
        for (int i = 1; i <= 10; i++) begin
            apply4(k, i);
            check("R9 chain step", {128'h0, out4}, ref_next({128'h0, k}, 4, i));
            k = out4;
        end
        check("R9 final key", {128'h0, k},
              {128'h0, 128'hd014f9a8_c9ee2589_e13f0cc8_b6630ca6});

        // R6: every round constant on a zero key
        for (int i = 1; i <= 10; i++) begin
            apply4(128'h0, i);
            check("R6 round constant", {128'h0, out4}, ref_next(256'h0, 4, i));
        end

        // R1: pure function, same inputs give same output after a different vector
        apply4(128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210, 3);
        rk = {128'h0, out4};
        apply4(128'hffff_ffff_0000_0000_ffff_ffff_0000_0000, 7);
        check("R1 follows input", {128'h0, out4},
              ref_next({128'h0, 128'hffff_ffff_0000_0000_ffff_ffff_0000_0000}, 4, 7));
        apply4(128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210, 3);
        check("R1 repeatable", {128'h0, out4}, rk);

        // R8: 256-bit key, first step
        apply8(256'h603deb10_15ca71be_2b73aef0_857d7781_1f352c07_3b6108d7_2d9810a3_0914dff4, 1);
        check("R8 wide key step", out8,
              256'h9ba35411_8e6925af_a51a8b5f_2067fcde_a8b09c1a_93d194cd_be49846e_b75d5b9a);

        // R3, R7: random 128-bit keys
        for (int i = 0; i < 200; i++) begin
            rk = rand_key();
            r  = 1 + int'($urandom % 10);
            apply4(rk[127:0], r);
            check("R3 R7 random narrow", {128'h0, out4}, ref_next({128'h0, rk[127:0]}, 4, r));
        end

        // R3, R7, R8: random 256-bit keys
        for (int i = 0; i < 200; i++) begin
            rk = rand_key();
            r  = 1 + int'($urandom % 7);
            apply8(rk, r);
            check("R8 R7 random wide", out8, ref_next(rk, 8, r));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule